// File: doc/BRIEF.md
# Keypad Passcode Verifier

This block checks a passcode that an operator types on a keypad. Characters arrive one at a time as ASCII bytes. The block keeps them in a seven-character shift buffer. When the operator presses the terminating enter key, the buffer is compared against a fixed table of fourteen passcodes. The table holds seven ordinary users and seven privileged users. The table is computed from a rule, so no memory is needed.

- An ordinary user's code is the text `user` followed by three ascending consecutive digits.
- A privileged user's code is the text `super` followed by two ascending consecutive digits.

After an enter, the block answers with exactly one single-cycle pulse: either an accept pulse or a reject pulse. An accept also reports the matching user number and a privilege flag. The central alarm controller uses that pulse as its login event.

A clear input abandons a partly typed entry. Every finished enter also empties the buffer, so the next entry starts fresh.

Top module: `pcode_verifier`

## Requirements
- R1: After reset, `loginValid`, `loginReject` and `isSuper` are 0 and `userIdx` is 0.
- R2: If the seven characters before enter are "user" followed by the digits n, n+1, n+2 (n = 1..7), then on the second rising edge after the enter edge `loginValid` is 1 for one cycle, `userIdx` = n and `isSuper` = 0.
- R3: If the seven characters before enter are "super" followed by the digits n, n+1 (n = 1..7), then at the same point `loginValid` is 1 for one cycle, `userIdx` = n and `isSuper` = 1.
- R4: Seven characters that match no table entry produce a one-cycle `loginReject` pulse at the same point, with `userIdx` = 0 and `isSuper` = 0.
- R5: An enter that follows fewer than or more than seven characters is rejected exactly as in R4, even when the first seven characters form a valid code.
- R6: Each enter that is not cancelled produces exactly one pulse, on `loginValid` or on `loginReject`, and never both. The pulse lasts one cycle.
- R7: `userIdx` and `isSuper` keep their value from the last result until the next result or a clear.
- R8: `clearIn` empties the buffer, resets the character count and sets `userIdx` and `isSuper` to 0. A clear in the cycle after an enter cancels that evaluation, so no pulse is produced.
- R9: A finished enter empties the buffer. Characters offered in the evaluation cycle, or in the same cycle as enter, are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| charValid | input | 1 | A keypad character is present this cycle |
| charData | input | 8 | ASCII code of the character |
| enterStb | input | 1 | Terminating enter key strobe |
| clearIn | input | 1 | Abandon entry and clear the result |
| loginValid | output | 1 | One-cycle accept pulse |
| loginReject | output | 1 | One-cycle reject pulse |
| isSuper | output | 1 | Accepted user holds privilege |
| userIdx | output | 3 | Number of the accepted user (1..7), 0 otherwise |

## Verification
The assertions assume that the inputs are sampled only at the clock edge. They also assume that `enterStb` and `clearIn` are single-cycle strobes, with the timing of any following input left unconstrained. The stimulus drives every input one time unit after a rising edge and holds it for exactly one cycle. A new entry starts only after the previous result has been observed, except in the directed cases that deliberately overlap a character or a clear with the evaluation cycle. The random entries are valid codes, single-character corruptions of valid codes, and truncated or lengthened codes. Together these cover the accept, reject and wrong-length paths.

// File: rtl/pcode_pkg.sv
package pcode_pkg;

  localparam int PC_LEN   = 7;
  localparam int PC_USERS = 7;

  typedef enum logic {ST_COLLECT, ST_EVAL} pcState_t;

  typedef struct packed {
    logic shiftIn;
    logic flush;
    logic evaluate;
    logic lenOk;
    logic clearResult;
  } pcStrobes_t;

  // Passcode for table entry k: entries below PC_USERS are ordinary users,
  // the rest privileged. The first character sits in the top byte.
  function automatic logic [8*PC_LEN-1:0] codeFor(input int k);
    logic [8*PC_LEN-1:0] r;
    logic [31:0] usr;
    logic [39:0] sup;
    logic [7:0]  c;
    int n;
    int plen;
    usr = "user";
    sup = "super";
    r = '0;
    if (k < PC_USERS) begin
      n = k + 1;
      plen = 4;
    end else begin
      n = k - PC_USERS + 1;
      plen = 5;
    end
    for (int i = 0; i < PC_LEN; i++) begin
      if (i < plen) begin
        if (k < PC_USERS) c = usr[8*(3-i) +: 8];
        else              c = sup[8*(4-i) +: 8];
      end else begin
        c = 8'(8'h30 + n + (i - plen));
      end
      r[8*(PC_LEN-1-i) +: 8] = c;
    end
    return r;
  endfunction

endpackage

// File: rtl/pcode_ctrl.sv
module pcode_ctrl
  import pcode_pkg::*;
#(
  parameter int LEN = PC_LEN
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       charValid,
  input  logic       enterStb,
  input  logic       clearIn,
  output pcStrobes_t strobes
);

  localparam int CNTW = $clog2(LEN + 2);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(LEN);
  localparam logic [CNTW-1:0] CNT_OVER = CNTW'(LEN + 1);

  pcState_t stateQ, stateD;
  logic [CNTW-1:0] countQ, countD;
  logic lenOkQ, lenOkD;

  always_comb begin
    stateD  = stateQ;
    countD  = countQ;
    lenOkD  = lenOkQ;
    strobes = '0;
    strobes.lenOk = lenOkQ;
    unique case (stateQ)
      ST_COLLECT: begin
        if (clearIn) begin
          strobes.flush       = 1'b1;
          strobes.clearResult = 1'b1;
          countD = '0;
        end else if (enterStb) begin
          lenOkD = (countQ == CNT_FULL);
          stateD = ST_EVAL;
        end else if (charValid) begin
          if (countQ < CNT_FULL) begin
            strobes.shiftIn = 1'b1;
            countD = countQ + 1'b1;
          end else begin
            countD = CNT_OVER;
          end
        end
      end
      ST_EVAL: begin
        strobes.flush = 1'b1;
        countD = '0;
        stateD = ST_COLLECT;
        if (clearIn) strobes.clearResult = 1'b1;
        else         strobes.evaluate    = 1'b1;
      end
      default: stateD = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_COLLECT;
      countQ <= '0;
      lenOkQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      countQ <= countD;
      lenOkQ <= lenOkD;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_OVER);  // R5
  AST_EVAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_EVAL |=> stateQ == ST_COLLECT && countQ == '0);  // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> countQ == '0);  // R8

endmodule

// File: rtl/pcode_datapath.sv
module pcode_datapath
  import pcode_pkg::*;
#(
  parameter int LEN   = PC_LEN,
  parameter int USERS = PC_USERS
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [7:0]                    charData,
  input  pcStrobes_t                    strobes,
  output logic                          loginValid,
  output logic                          loginReject,
  output logic                          isSuper,
  output logic [$clog2(USERS+1)-1:0]    userIdx
);

  localparam int BUFW    = 8 * LEN;
  localparam int ENTRIES = 2 * USERS;
  localparam int IDXW    = $clog2(USERS + 1);

  logic [BUFW-1:0]    bufQ;
  logic [ENTRIES-1:0] hit;
  logic               anyHit;
  logic               hitSuper;
  logic [IDXW-1:0]    hitIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ <= '0;
    end else if (strobes.flush) begin
      bufQ <= '0;
    end else if (strobes.shiftIn) begin
      bufQ <= {bufQ[BUFW-9:0], charData};
    end
  end

  for (genvar k = 0; k < ENTRIES; k++) begin : g_cmp
    assign hit[k] = (bufQ == codeFor(k));
  end

  always_comb begin
    anyHit   = 1'b0;
    hitSuper = 1'b0;
    hitIdx   = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (hit[k] && !anyHit) begin
        anyHit   = 1'b1;
        hitSuper = (k >= USERS);
        hitIdx   = (k < USERS) ? IDXW'(k + 1) : IDXW'(k - USERS + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loginValid  <= 1'b0;
      loginReject <= 1'b0;
      isSuper     <= 1'b0;
      userIdx     <= '0;
    end else begin
      loginValid  <= 1'b0;
      loginReject <= 1'b0;
      if (strobes.clearResult) begin
        isSuper <= 1'b0;
        userIdx <= '0;
      end else if (strobes.evaluate) begin
        if (strobes.lenOk && anyHit) begin
          loginValid <= 1'b1;
          isSuper    <= hitSuper;
          userIdx    <= hitIdx;
        end else begin
          loginReject <= 1'b1;
          isSuper     <= 1'b0;
          userIdx     <= '0;
        end
      end
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hit));  // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.evaluate && !strobes.clearResult |=> $stable(userIdx) && $stable(isSuper));  // R7

endmodule

// File: rtl/pcode_verifier.sv
module pcode_verifier
  import pcode_pkg::*;
#(
  parameter int LEN   = PC_LEN,
  parameter int USERS = PC_USERS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       charValid,
  input  logic [7:0] charData,
  input  logic       enterStb,
  input  logic       clearIn,
  output logic       loginValid,
  output logic       loginReject,
  output logic       isSuper,
  output logic [2:0] userIdx
);

  pcStrobes_t strobes;

  pcode_ctrl #(.LEN(LEN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .charValid (charValid),
    .enterStb  (enterStb),
    .clearIn   (clearIn),
    .strobes   (strobes)
  );

  pcode_datapath #(.LEN(LEN), .USERS(USERS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .charData    (charData),
    .strobes     (strobes),
    .loginValid  (loginValid),
    .loginReject (loginReject),
    .isSuper     (isSuper),
    .userIdx     (userIdx)
  );

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(loginValid && loginReject));  // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    loginValid |=> !loginValid);  // R6
  AST_VALID_HAS_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    loginValid |-> userIdx != 3'd0);  // R2
  AST_REJECT_NO_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    loginReject |-> userIdx == 3'd0 && !isSuper);  // R4
  AST_CLEAR_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> userIdx == 3'd0 && !isSuper && !loginValid && !loginReject);  // R8

endmodule

// File: tb/tb_pcode_verifier.sv
`timescale 1ns/1ps
module tb_pcode_verifier;

  logic       clk = 1'b0;
  logic       rstN;
  logic       charValid;
  logic [7:0] charData;
  logic       enterStb;
  logic       clearIn;
  logic       loginValid, loginReject, isSuper;
  logic [2:0] userIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pcode_verifier dut (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charData(charData),
    .enterStb(enterStb), .clearIn(clearIn), .loginValid(loginValid),
    .loginReject(loginReject), .isSuper(isSuper), .userIdx(userIdx)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string userCode(input int n);
    return $sformatf("user%0d%0d%0d", n, n + 1, n + 2);
  endfunction

  function automatic string superCode(input int n);
    return $sformatf("super%0d%0d", n, n + 1);
  endfunction

  // Expected result from the requirements: valid, privilege, index.
  function automatic void model(input string s, output int v, output int sp, output int idx);
    v = 0; sp = 0; idx = 0;
    if (s.len() != 7) return;
    for (int n = 1; n <= 7; n++) begin
      if (s == userCode(n))  begin v = 1; sp = 0; idx = n; end
      if (s == superCode(n)) begin v = 1; sp = 1; idx = n; end
    end
  endfunction

  task automatic sendChars(input string s);
    for (int i = 0; i < s.len(); i++) begin
      charValid = 1'b1;
      charData  = s[i];
      @(posedge clk); #1;
      charValid = 1'b0;
    end
  endtask

  task automatic pressEnter();
    enterStb = 1'b1;
    @(posedge clk); #1;
    enterStb = 1'b0;
  endtask

  task automatic login(input string s, input string req);
    int v, sp, idx;
    model(s, v, sp, idx);
    sendChars(s);
    pressEnter();
    @(posedge clk); #1;
    checkEq(req, {"valid ", s}, loginValid, v);
    checkEq(req, {"reject ", s}, loginReject, 1 - v);
    checkEq(req, {"super ", s}, isSuper, sp);
    checkEq(req, {"index ", s}, userIdx, idx);
    @(posedge clk); #1;
    checkEq("R6", {"pulse end ", s}, loginValid | loginReject, 0);
    checkEq("R7", {"index held ", s}, userIdx, idx);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    string s;
    int pick;
    rstN = 1'b0; charValid = 1'b0; charData = '0; enterStb = 1'b0; clearIn = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk); #1;
    checkEq("R1", "reset valid", loginValid, 0);
    checkEq("R1", "reset reject", loginReject, 0);
    checkEq("R1", "reset super", isSuper, 0);
    checkEq("R1", "reset index", userIdx, 0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // Directed corners
    login(userCode(1), "R2");
    login(userCode(7), "R2");
    login(superCode(1), "R3");
    login(superCode(7), "R3");
    login("user124", "R4");
    login("superab", "R4");
    login("super1", "R5");
    login("user1234", "R5");
    login("", "R5");

    // R7: result held over idle cycles
    login(superCode(4), "R3");
    repeat (5) @(posedge clk); #1;
    checkEq("R7", "idle index", userIdx, 4);
    checkEq("R7", "idle super", isSuper, 1);

    // R8: clear zeros the result and discards partial entry
    sendChars("xyz");
    clearIn = 1'b1; @(posedge clk); #1; clearIn = 1'b0;
    checkEq("R8", "clear index", userIdx, 0);
    checkEq("R8", "clear super", isSuper, 0);
    login(userCode(3), "R8");

    // R8: clear in evaluation cycle cancels the pulse
    sendChars(userCode(5));
    pressEnter();
    clearIn = 1'b1; @(posedge clk); #1; clearIn = 1'b0;
    checkEq("R8", "cancel valid", loginValid, 0);
    checkEq("R8", "cancel reject", loginReject, 0);
    checkEq("R8", "cancel index", userIdx, 0);
    @(posedge clk); #1;
    checkEq("R8", "cancel late pulse", loginValid | loginReject, 0);

    // R9: a character in the evaluation cycle is dropped
    sendChars(userCode(2));
    pressEnter();
    charValid = 1'b1; charData = "q";
    @(posedge clk); #1; charValid = 1'b0;
    checkEq("R9", "eval result", loginValid, 1);
    login(superCode(6), "R9");

    // R9: a character presented with enter is dropped
    sendChars(userCode(6));
    charValid = 1'b1; charData = "z"; enterStb = 1'b1;
    @(posedge clk); #1; charValid = 1'b0; enterStb = 1'b0;
    @(posedge clk); #1;
    checkEq("R9", "char with enter", loginValid, 1);
    checkEq("R9", "char with enter index", userIdx, 6);
    @(posedge clk); #1;

    // Random mix
    for (int it = 0; it < 200; it++) begin
      pick = $urandom % 4;
      if ($urandom % 2) s = userCode(1 + $urandom % 7);
      else              s = superCode(1 + $urandom % 7);
      if (pick == 2) begin
        s[$urandom % 7] = 8'(8'h30 + $urandom % 75);
      end else if (pick == 3) begin
        if ($urandom % 2) s = s.substr(0, 1 + $urandom % 5);
        else              s = {s, "9"};
      end
      if (pick == 3) login(s, "R5");
      else           login(s, (pick == 2) ? "R4" : "R2");
    end

    done = 1;
    finishRun();
  end

endmodule